// File: doc/BRIEF.md
# Receive FIFO with Hysteretic RTS Flow Control

This block sits between a UART receiver front end and the host side. Each received character arrives on a write strobe, together with three error flags. The block stores the character and its flags in a 32-entry first-in first-out buffer. The host reads characters from the head of the buffer, and the error tag of the head character is presented next to its data. The block reports the fill count. It raises a data-ready interrupt when the count reaches a level chosen from a fixed set of four.

The block also drives an active-low request-to-send output for automatic hardware flow control. RTS is withdrawn when the buffer fills to one rung of a fixed level ladder above the selected level. RTS is granted again when the buffer drains to one rung below it. This gap between the two points stops RTS from toggling near a single level. The data-ready interrupt level is separate from these flow-control points. A sticky interrupt records each withdrawal of RTS.

Top module: `rx_fifo_rts`

## Requirements
- R1: Characters leave in the order they were written. The head character's 8 data bits appear on `rd_data`, and its 3 error bits appear unchanged on `rd_err` (bit 0 of `wr_err` maps to bit 0 of `rd_err`). Both follow the head one cycle after a write into an empty buffer.
- R2: `fill` counts the stored characters. When the buffer is not empty, a read together with a write leaves `fill` unchanged. A read of an empty buffer has no effect. While the buffer is empty, `rd_data`/`rd_err` show the last character that was read out, or zero if none has been read since reset.
- R3: With `fifo_en` high, 32 characters can be stored. A write that finds the buffer full without a read in the same cycle is discarded and `ovr_strobe` is high for exactly the following cycle. Characters are still accepted while RTS is withdrawn, until the buffer is full.
- R4: `trig_irq` is high exactly while `fifo_en` is 1 and `fill` is at or above the selected level. `trig_sel` values 0, 1, 2 and 3 select 8, 16, 24 and 30.
- R5: In automatic mode, `rts_n` goes high at the clock edge where the updated fill count reaches 16, 24, 30 or 30, for `trig_sel` 0 to 3 in turn. Automatic mode means `auto_rts_en`, `fifo_en` and `rts_start` are all high, and `rts_start` was already high in the previous cycle.
- R6: In automatic mode with `rts_n` high, `rts_n` returns low at the edge where the updated fill count falls to 0, 8, 16 or 24, for `trig_sel` 0 to 3 in turn.
- R7: With `rts_start` low, `rts_n` is high from the next cycle on, whatever the fill level. In the first cycle `rts_start` is high after being low, RTS is granted (`rts_n` low next cycle). With `auto_rts_en` or `fifo_en` low, `rts_n` stays low while `rts_start` is high.
- R8: When `rts_irq_en` is high at the edge where `rts_n` goes from low to high, `rts_irq` goes high at that edge and stays high until `rts_irq_ack` is seen. If a new rise and an acknowledge arrive in the same cycle, the rise wins.
- R9: With `fifo_en` low, the buffer holds one character. Further writes are discarded as in R3, and `trig_irq` stays low.
- R10: After reset, `fill` is 0, `rts_n` is 1, and `trig_irq`, `rts_irq`, `ovr_strobe`, `rd_data` and `rd_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: 32-deep buffering and trigger; 0: single holding slot |
| trig_sel | input | 2 | Data-ready level select (8/16/24/30) |
| auto_rts_en | input | 1 | Enables automatic RTS hysteresis |
| rts_start | input | 1 | Software RTS on; low forces RTS off |
| rts_irq_en | input | 1 | Enables the RTS-withdrawn interrupt |
| rts_irq_ack | input | 1 | Clears the RTS interrupt |
| wr_en | input | 1 | Write strobe from the receiver front end |
| wr_data | input | 8 | Received character |
| wr_err | input | 3 | Error flags of the received character |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Head character (last read one when empty) |
| rd_err | output | 3 | Error tag of the head character |
| fill | output | 6 | Number of stored characters |
| trig_irq | output | 1 | Data-ready level reached |
| rts_irq | output | 1 | Sticky RTS-withdrawn interrupt |
| rts_n | output | 1 | Active-low request to send |
| ovr_strobe | output | 1 | One-cycle pulse after a discarded write |

## Verification
The assertions assume that the strobes and controls change only between clock edges and are never X after reset. They also assume that `rts_irq_en` and `rts_start` are sampled like any other registered input. The stimulus drives every input on the falling clock edge from a single process. It switches `trig_sel`, `fifo_en` and `auto_rts_en` at arbitrary fill levels, and the reference model follows those changes exactly, so mid-stream changes are legal stimulus rather than excluded cases. The random phases bias the read and write rates so that the buffer crosses every level of the ladder in both directions and spends time full and empty.

// File: rtl/rx_fifo_rts.sv
module rx_fifo_rts #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [1:0]        trig_sel,
  input  logic              auto_rts_en,
  input  logic              rts_start,
  input  logic              rts_irq_en,
  input  logic              rts_irq_ack,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic [TAG_W-1:0]  rd_err,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic              trig_irq,
  output logic              rts_irq,
  output logic              rts_n,
  output logic              ovr_strobe
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = DATA_W + TAG_W;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cnt_nxt, cap;
  logic [CW-1:0] lvl_trig, lvl_off, lvl_on;
  logic [EW-1:0] last_q, shown;
  logic          do_rd, do_wr;
  logic          rts_on, rts_on_nxt, start_q, irq_q, ovr_q;

  assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
  assign do_rd   = rd_en && (cnt != '0);
  assign do_wr   = wr_en && ((cnt < cap) || do_rd);
  assign cnt_nxt = cnt + CW'(do_wr) - CW'(do_rd);

  always_comb begin
    case (trig_sel)
      2'd0:    begin lvl_trig = CW'(8);  lvl_off = CW'(16); lvl_on = CW'(0);  end
      2'd1:    begin lvl_trig = CW'(16); lvl_off = CW'(24); lvl_on = CW'(8);  end
      2'd2:    begin lvl_trig = CW'(24); lvl_off = CW'(30); lvl_on = CW'(16); end
      default: begin lvl_trig = CW'(30); lvl_off = CW'(30); lvl_on = CW'(24); end
    endcase
  end

  always_comb begin
    rts_on_nxt = rts_on;
    if (!rts_start)                      rts_on_nxt = 1'b0;
    else if (!start_q)                   rts_on_nxt = 1'b1;
    else if (!(auto_rts_en && fifo_en))  rts_on_nxt = 1'b1;
    else if (rts_on && cnt_nxt >= lvl_off) rts_on_nxt = 1'b0;
    else if (!rts_on && cnt_nxt <= lvl_on) rts_on_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= {wr_err, wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      last_q  <= '0;
      rts_on  <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_rd) begin
        rp     <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
        last_q <= mem[rp];
      end
      cnt     <= cnt_nxt;
      rts_on  <= rts_on_nxt;
      start_q <= rts_start;
      ovr_q   <= wr_en && !do_wr;
      if (rts_on && !rts_on_nxt && rts_irq_en) irq_q <= 1'b1;
      else if (rts_irq_ack)                    irq_q <= 1'b0;
    end
  end

  assign shown      = (cnt == '0) ? last_q : mem[rp];
  assign rd_data    = shown[DATA_W-1:0];
  assign rd_err     = shown[EW-1:DATA_W];
  assign fill       = cnt;
  assign trig_irq   = fifo_en && (cnt >= lvl_trig);
  assign rts_irq    = irq_q;
  assign rts_n      = !rts_on;
  assign ovr_strobe = ovr_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R3
  ovr_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && cnt == CW'(DEPTH)) |=> (ovr_strobe && fill == CW'(DEPTH)));

  // R2
  empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && cnt == '0) |=> (fill == '0 && $stable(rd_data)));

  // R7
  rts_forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_start |=> rts_n);

  // R8
  rts_irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && $past(rts_irq_en)) |-> rts_irq);

  // R9
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && wr_en && !rd_en && cnt != '0) |=> ovr_strobe);
endmodule

// File: tb/rx_fifo_rts_bench.sv
module rx_fifo_rts_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fifo_en = 0, auto_rts_en = 0, rts_start = 0, rts_irq_en = 0, rts_irq_ack = 0;
  logic [1:0] trig_sel = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] wr_err = 0;
  logic [7:0] rd_data;
  logic [2:0] rd_err;
  logic [5:0] fill;
  logic trig_irq, rts_irq, rts_n, ovr_strobe;

  always #(CLK_P/2) clk = ~clk;

  rx_fifo_rts u_rx_fifo_rts (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .rts_start(rts_start), .rts_irq_en(rts_irq_en),
    .rts_irq_ack(rts_irq_ack), .wr_en(wr_en), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .fill(fill),
    .trig_irq(trig_irq), .rts_irq(rts_irq), .rts_n(rts_n), .ovr_strobe(ovr_strobe));

  int checks = 0, fails = 0;
  logic [10:0] q[$];
  logic [10:0] m_last = 0;
  bit m_on = 0, m_startq = 0, m_irq = 0, m_ovr = 0;

  task automatic chk(string rq, string nm, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h at %0t", rq, nm, got, exp, $time);
    end
  endtask

  function automatic int lv(int sel, int which);
    int t[4] = '{8, 16, 24, 30};
    int f[4] = '{16, 24, 30, 30};
    int o[4] = '{0, 8, 16, 24};
    return which == 0 ? t[sel] : which == 1 ? f[sel] : o[sel];
  endfunction

  task automatic model_step();
    int cap = fifo_en ? 32 : 1;
    bit dr = rd_en && q.size() > 0;
    bit dw = wr_en && (q.size() < cap || dr);
    bit nx = m_on;
    int n;
    if (dr) m_last = q.pop_front();
    if (dw) q.push_back({wr_err, wr_data});
    m_ovr = wr_en && !dw;
    n = q.size();
    if (!rts_start) nx = 0;
    else if (!m_startq) nx = 1;
    else if (!(auto_rts_en && fifo_en)) nx = 1;
    else if (m_on && n >= lv(trig_sel, 1)) nx = 0;
    else if (!m_on && n <= lv(trig_sel, 2)) nx = 1;
    if (m_on && !nx && rts_irq_en) m_irq = 1;
    else if (rts_irq_ack) m_irq = 0;
    m_on = nx;
    m_startq = rts_start;
  endtask

  task automatic compare();
    logic [10:0] h = q.size() > 0 ? q[0] : m_last;
    chk("R1", "rd_data", rd_data, h[7:0]);
    chk("R1", "rd_err", rd_err, h[10:8]);
    chk("R2", "fill", fill, q.size());
    chk("R3", "ovr_strobe", ovr_strobe, m_ovr);
    chk("R4", "trig_irq", trig_irq, fifo_en && q.size() >= lv(trig_sel, 0));
    chk("R5 R6 R7", "rts_n", rts_n, !m_on);
    chk("R8", "rts_irq", rts_irq, m_irq);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic put(int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; rd_en = 0; wr_data = 8'($urandom); wr_err = 3'($urandom);
      tick();
    end
    wr_en = 0;
  endtask

  task automatic take(int n);
    for (int i = 0; i < n; i++) begin
      rd_en = 1; wr_en = 0;
      tick();
    end
    rd_en = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: reset state
    chk("R10", "fill", fill, 0);
    chk("R10", "rts_n", rts_n, 1);
    chk("R10", "irqs", {trig_irq, rts_irq, ovr_strobe}, 0);
    chk("R10", "head", {rd_err, rd_data}, 0);

    // R7: start RTS, auto hysteresis at trigger 16
    fifo_en = 1; auto_rts_en = 1; rts_irq_en = 1; trig_sel = 1; rts_start = 1;
    tick();
    chk("R7", "rts_n granted", rts_n, 0);
    // R1: head follows one cycle after first write
    wr_en = 1; wr_data = 8'hA5; wr_err = 3'b101; tick(); wr_en = 0;
    chk("R1", "first head", {rd_err, rd_data}, {3'b101, 8'hA5});
    put(22);
    chk("R5", "rts_n below off", rts_n, 0);
    put(1);
    chk("R5", "rts_n at 24", rts_n, 1);
    chk("R8", "rts_irq set", rts_irq, 1);
    // R3: accepted while RTS off, until full, then discarded
    put(8);
    chk("R3", "full", fill, 32);
    put(1);
    chk("R3", "overrun", ovr_strobe, 1);
    chk("R3", "fill held", fill, 32);
    tick();
    chk("R3", "ovr one cycle", ovr_strobe, 0);
    // R2: simultaneous read and write when full
    wr_en = 1; rd_en = 1; tick(); wr_en = 0; rd_en = 0;
    chk("R2", "rd+wr full", fill, 32);
    rts_irq_ack = 1; tick(); rts_irq_ack = 0;
    chk("R8", "ack", rts_irq, 0);
    take(23);
    chk("R6", "rts_n above on", rts_n, 1);
    take(1);
    chk("R6", "rts_n at 8", rts_n, 0);
    take(8);
    take(2); // R2: reads of empty
    chk("R2", "empty", fill, 0);

    // R4 R5 R6: every ladder step
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      put(32); take(32);
    end

    // R7: clearing start forces RTS off, auto disabled keeps RTS on
    put(4); rts_start = 0; tick();
    chk("R7", "forced off", rts_n, 1);
    rts_start = 1; auto_rts_en = 0; tick();
    put(28);
    chk("R7", "manual on", rts_n, 0);
    auto_rts_en = 1; take(32);

    // R9: single slot
    fifo_en = 0; put(3);
    chk("R9", "one slot", fill, 1);
    chk("R9", "no trig", trig_irq, 0);
    take(2);

    // random phases over all controls
    for (int b = 0; b < 60; b++) begin
      int pw = $urandom_range(20, 90);
      int pr = $urandom_range(20, 90);
      trig_sel = 2'($urandom);
      fifo_en = ($urandom_range(0, 9) != 0);
      auto_rts_en = ($urandom_range(0, 7) != 0);
      rts_irq_en = $urandom_range(0, 3) != 0;
      for (int c = 0; c < 150; c++) begin
        wr_en = $urandom_range(0, 99) < pw;
        rd_en = $urandom_range(0, 99) < pr;
        wr_data = 8'($urandom); wr_err = 3'($urandom);
        rts_start = $urandom_range(0, 49) != 0;
        rts_irq_ack = $urandom_range(0, 19) == 0;
        tick();
      end
    end
    wr_en = 0; rd_en = 0; rts_irq_ack = 0;
    tick();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule